// File: doc/BRIEF.md
# Return-Address Stack Sequencer

This block is the call/return stack engine of an 8-bit processor whose program counter is 16 bits wide. The instruction decoder gives it one-cycle command pulses: subroutine call, subroutine return, interrupt entry and return from interrupt. The block turns each command into a short run of byte writes or reads on a synchronous single-port memory and keeps the 8-bit stack pointer. Every stack byte lives in the fixed page whose high address byte is 0x01, and the stack grows toward lower addresses.

On a call the block saves the return address minus one. On an interrupt it saves the program counter and then the status byte. A return reads back the two address bytes and adds one to the result. A return from interrupt restores the status byte and the exact program counter. While a command runs, the block holds `busy` high and ignores any new pulse. When the command finishes it raises `done` for one cycle.

States are `ST_IDLE`, `ST_PUSH_HI`, `ST_PUSH_LO`, `ST_PUSH_ST`, `ST_PULL_ST`, `ST_PULL_LO`, `ST_PULL_HI`, `ST_PULL_END` and `ST_DONE`. The transitions are:
- `ST_IDLE` goes to `ST_PUSH_HI` on an interrupt or a call, to `ST_PULL_ST` on a return from interrupt, and to `ST_PULL_LO` on a return.
- `ST_PUSH_HI` goes to `ST_PUSH_LO`.
- `ST_PUSH_LO` goes to `ST_PUSH_ST` for an interrupt and to `ST_DONE` for a call.
- `ST_PUSH_ST` goes to `ST_DONE`.
- `ST_PULL_ST` goes to `ST_PULL_LO`, which goes to `ST_PULL_HI`, then to `ST_PULL_END`, then to `ST_DONE`.
- `ST_DONE` goes back to `ST_IDLE`.

Top module: `callstack_seq`

## Requirements
- R1: After reset `sp_out` is 0xFF, and `busy`, `done`, `mem_we` and `mem_re` are all 0.
- R2: Every memory access uses 0x01 as the high address byte. A write uses `sp_out` as the low byte. A read uses `sp_out`+1 (mod 256) as the low byte.
- R3: Each write decrements the stack pointer by one after the write. Each read increments it by one. Both wrap modulo 256 and raise no fault. With no access, the pointer holds.
- R4: A call takes `pc_in` as the address of the next instruction. It writes the high byte of `pc_in`-1 and then its low byte, in the two cycles after acceptance. `done` is high in the third cycle after acceptance.
- R5: An interrupt writes the high byte of `pc_in`, then its low byte, then `status_in`, in three consecutive cycles. `done` follows in the fourth cycle.
- R6: A return reads the low byte and then the high byte. It loads `pc_out` with the assembled value plus one, modulo 2^16. `done` is high in the fourth cycle after acceptance.
- R7: A return from interrupt reads the status byte, then the low byte, then the high byte. It loads `status_out` and `pc_out` with no adjustment. `done` is high in the fifth cycle after acceptance.
- R8: `busy` is high from the cycle after acceptance through the `done` cycle. A command pulse that arrives while `busy` is high causes no memory access and does not change the pointer.
- R9: When several pulses arrive together in idle, only one is run. The priority is interrupt, then return from interrupt, then call, then return.
- R10: Read data is taken from `mem_rdata` in the cycle after the read address is presented.
- R11: `pc_out` and `status_out` change only at the end of a return or a return from interrupt. A call leaves both unchanged, and a return leaves `status_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_call | input | 1 | Subroutine call pulse |
| cmd_ret | input | 1 | Subroutine return pulse |
| cmd_irq | input | 1 | Interrupt entry pulse |
| cmd_rti | input | 1 | Return-from-interrupt pulse |
| pc_in | input | 16 | Program counter to save (for a call, the next-instruction address) |
| status_in | input | 8 | Status byte to save on interrupt entry |
| mem_rdata | input | 8 | Read data, valid one cycle after the read address |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 8 | Stack memory write data |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read enable |
| pc_out | output | 16 | Restored program counter |
| status_out | output | 8 | Restored status byte |
| sp_out | output | 8 | Current stack pointer |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |

## Verification
The assertions check on every cycle the properties that hold in every cycle. Each write leaves the pointer one below the address it used, and each read leaves it at the address it used. The pointer holds when there is no access, a read and a write never happen together, an accepted command raises `busy` in the next cycle, and `busy` falls after `done`. The bench scenarios show the rest. They show the byte order and values of each frame, the minus-one and plus-one adjustments (including the wrap from 0x0000 to 0xFFFF and back), and pointer wrap at both ends of the page. They also show the latency of each command, the priority among simultaneous pulses, and that pulses sent while `busy` is high are ignored.

// File: rtl/callstack_pkg.sv
package callstack_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_ST,
        ST_PULL_ST,
        ST_PULL_LO,
        ST_PULL_HI,
        ST_PULL_END,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_CALL,
        OP_RET,
        OP_IRQ,
        OP_RTI
    } stack_op_e;

    typedef enum logic [1:0] {
        WSEL_HI,
        WSEL_LO,
        WSEL_ST
    } wsel_e;

endpackage

// File: rtl/callstack_ptr.sv
module callstack_ptr #(
    parameter int          PTR_W    = 8,
    parameter logic [PTR_W-1:0] PTR_INIT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec,
    input  logic             inc,
    output logic [PTR_W-1:0] ptr,
    output logic [PTR_W-1:0] ptr_up
);

    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= PTR_INIT;
        end else if (dec) begin
            ptr <= ptr - ONE;
        end else if (inc) begin
            ptr <= ptr + ONE;
        end
    end

    assign ptr_up = ptr + ONE;

    // R3: pointer moves by exactly one per access, wrapping
    a_r3_push_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        dec |=> ptr == $past(ptr) - ONE);
    a_r3_pull_increments: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> ptr == $past(ptr) + ONE);
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec && !inc) |=> $stable(ptr));

endmodule

// File: rtl/callstack_ctrl.sv
module callstack_ctrl
    import callstack_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cmd_call,
    input  logic  cmd_ret,
    input  logic  cmd_irq,
    input  logic  cmd_rti,
    output logic  accept,
    output logic  accept_call,
    output logic  mem_we,
    output logic  mem_re,
    output logic  ptr_dec,
    output logic  ptr_inc,
    output wsel_e wsel,
    output logic  cap_st,
    output logic  cap_lo,
    output logic  load_pc,
    output logic  plus_one,
    output logic  load_st,
    output logic  busy,
    output logic  done
);

    seq_state_e state_q, state_d;
    stack_op_e  op_q, op_d;
    logic       any_cmd;

    assign any_cmd = cmd_call | cmd_ret | cmd_irq | cmd_rti;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_CALL;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
        end
    end

    // next-state logic with R9 priority
    always_comb begin
        state_d = state_q;
        op_d    = op_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_irq) begin
                    op_d    = OP_IRQ;
                    state_d = ST_PUSH_HI;
                end else if (cmd_rti) begin
                    op_d    = OP_RTI;
                    state_d = ST_PULL_ST;
                end else if (cmd_call) begin
                    op_d    = OP_CALL;
                    state_d = ST_PUSH_HI;
                end else if (cmd_ret) begin
                    op_d    = OP_RET;
                    state_d = ST_PULL_LO;
                end
            end
            ST_PUSH_HI:  state_d = ST_PUSH_LO;
            ST_PUSH_LO:  state_d = (op_q == OP_IRQ) ? ST_PUSH_ST : ST_DONE;
            ST_PUSH_ST:  state_d = ST_DONE;
            ST_PULL_ST:  state_d = ST_PULL_LO;
            ST_PULL_LO:  state_d = ST_PULL_HI;
            ST_PULL_HI:  state_d = ST_PULL_END;
            ST_PULL_END: state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // output logic
    always_comb begin
        accept      = (state_q == ST_IDLE) && any_cmd;
        accept_call = accept && !cmd_irq && !cmd_rti && cmd_call;
        mem_we      = 1'b0;
        mem_re      = 1'b0;
        wsel        = WSEL_HI;
        cap_st      = 1'b0;
        cap_lo      = 1'b0;
        load_pc     = 1'b0;
        load_st     = 1'b0;
        plus_one    = (op_q == OP_RET);
        done        = 1'b0;
        busy        = (state_q != ST_IDLE);
        unique case (state_q)
            ST_PUSH_HI: begin
                mem_we = 1'b1;
                wsel   = WSEL_HI;
            end
            ST_PUSH_LO: begin
                mem_we = 1'b1;
                wsel   = WSEL_LO;
            end
            ST_PUSH_ST: begin
                mem_we = 1'b1;
                wsel   = WSEL_ST;
            end
            ST_PULL_ST: mem_re = 1'b1;
            ST_PULL_LO: begin
                mem_re = 1'b1;
                cap_st = (op_q == OP_RTI);
            end
            ST_PULL_HI: begin
                mem_re = 1'b1;
                cap_lo = 1'b1;
            end
            ST_PULL_END: begin
                load_pc = 1'b1;
                load_st = (op_q == OP_RTI);
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
        ptr_dec = mem_we;
        ptr_inc = mem_re;
    end

    // R8: acceptance raises busy next cycle
    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && any_cmd) |=> busy);
    // R8: busy drops right after done
    a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R2: one access kind at a time
    a_r2_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
    // R10: captures follow a read issued the cycle before
    a_r10_capture_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_lo || cap_st || load_pc) |-> $past(mem_re));

endmodule

// File: rtl/callstack_data.sv
module callstack_data
    import callstack_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PC_W   = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              accept_call,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [BYTE_W-1:0] status_in,
    input  wsel_e             wsel,
    output logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] rdata,
    input  logic              cap_st,
    input  logic              cap_lo,
    input  logic              load_pc,
    input  logic              plus_one,
    input  logic              load_st,
    output logic [PC_W-1:0]   pc_out,
    output logic [BYTE_W-1:0] status_out
);

    localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

    logic [PC_W-1:0]   push_val;
    logic [BYTE_W-1:0] st_hold;
    logic [BYTE_W-1:0] st_cap;
    logic [BYTE_W-1:0] lo_cap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_val   <= '0;
            st_hold    <= '0;
            st_cap     <= '0;
            lo_cap     <= '0;
            pc_out     <= '0;
            status_out <= '0;
        end else begin
            if (accept) begin
                push_val <= accept_call ? (pc_in - PC_ONE) : pc_in;
                st_hold  <= status_in;
            end
            if (cap_st) st_cap <= rdata;
            if (cap_lo) lo_cap <= rdata;
            if (load_pc) pc_out <= {rdata, lo_cap} + (plus_one ? PC_ONE : '0);
            if (load_st) status_out <= st_cap;
        end
    end

    always_comb begin
        unique case (wsel)
            WSEL_HI: wdata = push_val[PC_W-1 -: BYTE_W];
            WSEL_LO: wdata = push_val[BYTE_W-1:0];
            WSEL_ST: wdata = st_hold;
            default: wdata = '0;
        endcase
    end

    // R11: restored values move only on a load
    a_r11_pc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !load_pc |=> $stable(pc_out));
    a_r11_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !load_st |=> $stable(status_out));

endmodule

// File: rtl/callstack_seq.sv
module callstack_seq
    import callstack_pkg::*;
#(
    parameter int               BYTE_W    = 8,
    parameter int               PC_W      = 2 * BYTE_W,
    parameter logic [BYTE_W-1:0] STACK_PG = 8'h01,
    parameter logic [BYTE_W-1:0] SP_RESET = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_call,
    input  logic              cmd_ret,
    input  logic              cmd_irq,
    input  logic              cmd_rti,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [BYTE_W-1:0] status_in,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [PC_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [PC_W-1:0]   pc_out,
    output logic [BYTE_W-1:0] status_out,
    output logic [BYTE_W-1:0] sp_out,
    output logic              busy,
    output logic              done
);

    logic        accept, accept_call;
    logic        ptr_dec, ptr_inc;
    logic        cap_st, cap_lo, load_pc, plus_one, load_st;
    wsel_e       wsel;
    logic [BYTE_W-1:0] sp_up;

    callstack_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_call    (cmd_call),
        .cmd_ret     (cmd_ret),
        .cmd_irq     (cmd_irq),
        .cmd_rti     (cmd_rti),
        .accept      (accept),
        .accept_call (accept_call),
        .mem_we      (mem_we),
        .mem_re      (mem_re),
        .ptr_dec     (ptr_dec),
        .ptr_inc     (ptr_inc),
        .wsel        (wsel),
        .cap_st      (cap_st),
        .cap_lo      (cap_lo),
        .load_pc     (load_pc),
        .plus_one    (plus_one),
        .load_st     (load_st),
        .busy        (busy),
        .done        (done)
    );

    callstack_ptr #(
        .PTR_W    (BYTE_W),
        .PTR_INIT (SP_RESET)
    ) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .dec    (ptr_dec),
        .inc    (ptr_inc),
        .ptr    (sp_out),
        .ptr_up (sp_up)
    );

    callstack_data #(
        .BYTE_W (BYTE_W),
        .PC_W   (PC_W)
    ) u_data (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .accept_call (accept_call),
        .pc_in       (pc_in),
        .status_in   (status_in),
        .wsel        (wsel),
        .wdata       (mem_wdata),
        .rdata       (mem_rdata),
        .cap_st      (cap_st),
        .cap_lo      (cap_lo),
        .load_pc     (load_pc),
        .plus_one    (plus_one),
        .load_st     (load_st),
        .pc_out      (pc_out),
        .status_out  (status_out)
    );

    assign mem_addr = {STACK_PG, (mem_re ? sp_up : sp_out)};

    // R2/R3: a write leaves the pointer one below its address
    a_r3_write_then_dec: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp_out == $past(mem_addr[BYTE_W-1:0]) - BYTE_W'(1));
    // R2/R3: a read leaves the pointer at its address
    a_r3_read_after_inc: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> sp_out == $past(mem_addr[BYTE_W-1:0]));
    // R8: pulses while busy cause no new command start
    a_r8_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

// File: tb/callstack_seq_tb_top.sv
module callstack_seq_tb_top;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_call = 1'b0, cmd_ret = 1'b0, cmd_irq = 1'b0, cmd_rti = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  status_in = '0;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we, mem_re;
    logic [15:0] pc_out;
    logic [7:0]  status_out;
    logic [7:0]  sp_out;
    logic        busy, done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic        we;
        logic [15:0] addr;
        logic [7:0]  data;
        string       req;
    } ev_t;
    ev_t exp_q[$];

    logic [7:0]  mem [256];
    logic [7:0]  bsp;
    logic [15:0] exp_pc;
    logic [7:0]  exp_st;

    always #(CLK_PERIOD/2) clk = ~clk;

    callstack_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_call(cmd_call), .cmd_ret(cmd_ret), .cmd_irq(cmd_irq), .cmd_rti(cmd_rti),
        .pc_in(pc_in), .status_in(status_in), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .pc_out(pc_out), .status_out(status_out), .sp_out(sp_out),
        .busy(busy), .done(done)
    );

    // page-1 memory model, one-cycle read latency (R10)
    initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !finished && (mem_we || mem_re)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected access addr", longint'(mem_addr), 0);
            end else begin
                ev_t e;
                e = exp_q.pop_front();
                chk(mem_we == e.we, e.req, "access kind we", longint'(mem_we), longint'(e.we));
                chk(mem_addr == e.addr, e.req, "access addr", longint'(mem_addr), longint'(e.addr));
                if (e.we)
                    chk(mem_wdata == e.data, e.req, "write data", longint'(mem_wdata), longint'(e.data));
            end
        end
    end

    function automatic void push_w(input logic [7:0] d, input string req);
        exp_q.push_back('{1'b1, {8'h01, bsp}, d, req});
        bsp = bsp - 8'd1;
    endfunction

    function automatic logic [7:0] pull_r(input string req);
        bsp = bsp + 8'd1;
        exp_q.push_back('{1'b0, {8'h01, bsp}, 8'h00, req});
        return mem[bsp];
    endfunction

    // driver: issue pulses, predict frame, wait for done
    task automatic run_cmd(input bit c, input bit r, input bit i, input bit t,
                           input logic [15:0] pc, input logic [7:0] st,
                           input bit extra_ret);
        int lat, n;
        string req;
        logic [7:0] b0, b1, b2;
        logic [15:0] pm1;
        @(negedge clk);
        cmd_call = c; cmd_ret = r; cmd_irq = i; cmd_rti = t;
        pc_in = pc; status_in = st;
        if (i) begin
            req = "R5"; lat = 4;
            push_w(pc[15:8], req); push_w(pc[7:0], req); push_w(st, req);
        end else if (t) begin
            req = "R7"; lat = 5;
            b0 = pull_r(req); b1 = pull_r(req); b2 = pull_r(req);
            exp_st = b0; exp_pc = {b2, b1};
        end else if (c) begin
            req = "R4"; lat = 3;
            pm1 = pc - 16'd1;
            push_w(pm1[15:8], req); push_w(pm1[7:0], req);
        end else begin
            req = "R6"; lat = 4;
            b0 = pull_r(req); b1 = pull_r(req);
            exp_pc = {b1, b0} + 16'd1;
        end
        @(negedge clk);
        cmd_call = 1'b0; cmd_irq = 1'b0; cmd_rti = 1'b0;
        cmd_ret = extra_ret;
        if (extra_ret) chk(busy == 1'b1, "R8", "busy during command", busy, 1);
        n = 1;
        while (!done && n < 12) begin
            @(negedge clk);
            cmd_ret = 1'b0;
            n++;
        end
        cmd_ret = 1'b0;
        chk(n == lat, req, "done latency", n, lat);
        chk(busy == 1'b1, "R8", "busy in done cycle", busy, 1);
        chk(pc_out == exp_pc, (r || t) ? req : "R11", "pc_out", pc_out, exp_pc);
        chk(status_out == exp_st, t ? req : "R11", "status_out", status_out, exp_st);
        @(negedge clk);
        chk(!busy && !done, "R8", "idle after done", {busy, done}, 0);
        chk(sp_out == bsp, "R3", "stack pointer", sp_out, bsp);
        chk(exp_q.size() == 0, req, "pending accesses", exp_q.size(), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bsp = 8'hFF; exp_pc = 16'h0000; exp_st = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sp_out == 8'hFF, "R1", "sp after reset", sp_out, 8'hFF);
        chk({busy, done, mem_we, mem_re} == 4'b0, "R1", "flags after reset",
            {busy, done, mem_we, mem_re}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sp_out == 8'hFF && !busy, "R1", "idle after release", sp_out, 8'hFF);

        // R4 call then R6 return; R11 call leaves pc_out alone
        run_cmd(1, 0, 0, 0, 16'h1234, 8'h00, 0);
        run_cmd(0, 1, 0, 0, 16'h0000, 8'h00, 0);
        chk(pc_out == 16'h1234, "R6", "return to call site", pc_out, 16'h1234);

        // R5 interrupt then R7 return from interrupt
        run_cmd(0, 0, 1, 0, 16'hABCD, 8'hA5, 0);
        run_cmd(0, 0, 0, 1, 16'h0000, 8'h00, 0);
        chk(pc_out == 16'hABCD && status_out == 8'hA5, "R7", "restored frame",
            {pc_out, status_out}, {16'hABCD, 8'hA5});

        // R4/R6 wrap of minus one and plus one
        run_cmd(1, 0, 0, 0, 16'h0000, 8'h00, 0);
        run_cmd(0, 1, 0, 0, 16'h0000, 8'h00, 0);
        chk(pc_out == 16'h0000, "R6", "plus-one wrap", pc_out, 0);

        // R3 pointer underflow wrap: return from 0xFF reads 0x0100, 0x0101
        run_cmd(0, 1, 0, 0, 16'h0000, 8'h00, 0);
        // R3 pointer wrap downward through 0x00
        run_cmd(1, 0, 0, 0, 16'h8001, 8'h00, 0);

        // R9 priority: interrupt beats call; return from interrupt beats return
        run_cmd(1, 0, 1, 0, 16'h4321, 8'h3C, 0);
        run_cmd(0, 1, 0, 1, 16'h0000, 8'h00, 0);
        chk(pc_out == 16'h4321 && status_out == 8'h3C, "R9", "priority frame",
            {pc_out, status_out}, {16'h4321, 8'h3C});

        // R8 pulse while busy is ignored
        run_cmd(1, 0, 0, 0, 16'h2000, 8'h00, 1);
        repeat (3) @(negedge clk);
        chk(!busy && sp_out == bsp, "R8", "no extra command", sp_out, bsp);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule